// File: doc/BRIEF.md
# Clock Generator Control Register Slave (Two-Wire)

This block is the serial control port of a clock generator. It watches a two-wire serial bus (SCL, SDA), sampled on a faster system clock, and holds a small bank of byte-wide registers. The outputs of those registers feed the enable and mode inputs of the clock gating logic. At reset every register loads a default value, so the clocks run without any serial access.

A write is a block transfer. The host sends a start, the write address byte, a fixed command byte of zero, a byte count, and then data bytes. The data bytes fill the registers from register 0 upward. To reach register N, the host must first resend registers 0 to N-1. A read uses the read address byte. The block then returns the registers from register 0 upward, one byte per acknowledge from the host.

The block drives SDA open-drain only: it either pulls the line low or releases it. It never stretches the clock and does not take part in arbitration. The register interface is plain, with no valid/ready handshake, because every register is always valid and the clock gating logic never applies back-pressure.

Top module: `clkctl_i2c_slave`

## Requirements
- R1: After reset every register reads 8'hFF on `ctrl_regs` (register i occupies bits 8i+7 down to 8i), and `sda_oe` is low.
- R2: A start condition (SDA falls while SCL is high) followed by the byte 8'hD2 is acknowledged: the slave pulls SDA low during the ninth clock.
- R3: When the first byte after a start is neither 8'hD2 nor 8'hD3, the slave does not acknowledge it, acknowledges nothing else, and changes no register until the next start.
- R4: After 8'hD2, a second byte other than 8'h00 is not acknowledged, and the rest of that transaction is ignored.
- R5: After 8'hD2 and 8'h00, the byte count is always acknowledged. Each later data byte k (k = 0, 1, ...) is written to register k and acknowledged, counting from 0 anew in each transaction.
- R6: A data byte whose index k is not below the byte count, or not below the number of registers (6), is neither acknowledged nor written.
- R7: After an acknowledged 8'hD3, the slave sends register 0, then the following registers in order, MSB first. It stops driving after each byte so the host can acknowledge. Every index past the last register reads 8'hFF. After the host answers a byte with no acknowledge, the slave drives nothing more until the next start.
- R8: A stop condition (SDA rises while SCL is high) ends the transaction. Bytes clocked after a stop and before a new start are not acknowledged, and writes already made remain.
- R9: A repeated start in the middle of a write restarts the address phase. The registers written before it keep their new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line as received |
| sda_i | input | 1 | Serial data line as received |
| sda_oe | output | 1 | When high, the pad pulls SDA low; when low, SDA is released |
| ctrl_regs | output | 8*NUM_REGS | Register bank contents, register i at bits 8i+7:8i |

## Verification
The bench walks several write transactions. These cover a wrong address, a wrong command code, a zero byte count, a count smaller than the bytes sent, a count larger than the bank, and fewer bytes than the count. After each write it reads the whole bank back, one byte past the end. An off-by-one in the count or index check shows up as an acknowledge on a byte that should be refused, or as a register that should have kept its value but changed. A slave that keeps sending after the host's no-acknowledge would pull SDA low on the extra byte the bench clocks. A slave that does not reset its state on a stop or a repeated start would acknowledge a stray byte, or lose the register written just before the restart.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_MACK, PH_SKIP
  } phase_e;

  typedef enum logic [1:0] {
    BK_ADDR, BK_CMD, BK_COUNT, BK_DATA
  } byte_kind_e;

  localparam logic [6:0] SLAVE_ID   = 7'b1101001;
  localparam logic [7:0] BLOCK_CMD  = 8'h00;
endpackage

// File: rtl/clkctl_line_sync.sv
module clkctl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank #(
  parameter int         NUM_REGS     = 6,
  parameter logic [7:0] DEFAULT_FILL = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_idx,
  output logic [7:0]            rd_data,
  output logic [8*NUM_REGS-1:0] regs_flat
);
  logic [7:0] bank [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank[g] <= DEFAULT_FILL;
      else if (wr_en && wr_idx == 8'(g))
        bank[g] <= wr_data;
    end
    assign regs_flat[8*g +: 8] = bank[g];
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == 8'(i)) rd_data = bank[i];
  end
endmodule

// File: rtl/clkctl_i2c_fsm.sv
module clkctl_i2c_fsm
  import clkctl_pkg::*;
#(
  parameter int NUM_REGS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] rd_idx
);
  localparam logic [7:0] REG_LIMIT = 8'(NUM_REGS);

  phase_e     phase;
  byte_kind_e kind;
  logic [2:0] bitcnt;
  logic [7:0] shreg, txsh, budget, idx;
  logic       byte_full, rd_mode, host_ack;
  logic       byte_done, data_ok;

  assign byte_done = (phase == PH_RX) && scl_fall && byte_full;
  assign data_ok   = (idx < budget) && (idx < REG_LIMIT);
  assign wr_en     = byte_done && (kind == BK_DATA) && data_ok;
  assign wr_idx    = idx;
  assign wr_data   = shreg;
  assign rd_idx    = idx;
  assign sda_oe    = (phase == PH_ACK) || ((phase == PH_TX) && !txsh[7]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      kind      <= BK_ADDR;
      bitcnt    <= '0;
      shreg     <= '0;
      txsh      <= 8'hFF;
      budget    <= '0;
      idx       <= '0;
      byte_full <= 1'b0;
      rd_mode   <= 1'b0;
      host_ack  <= 1'b0;
    end else if (start_det) begin
      phase     <= PH_RX;
      kind      <= BK_ADDR;
      bitcnt    <= '0;
      byte_full <= 1'b0;
      rd_mode   <= 1'b0;
    end else if (stop_det) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_RX: begin
          if (scl_rise && !byte_full) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) byte_full <= 1'b1;
          end
          if (byte_done) begin
            byte_full <= 1'b0;
            phase     <= PH_SKIP;
            unique case (kind)
              BK_ADDR:
                if (shreg[7:1] == SLAVE_ID) begin
                  phase   <= PH_ACK;
                  rd_mode <= shreg[0];
                  kind    <= BK_CMD;
                  idx     <= '0;
                end
              BK_CMD:
                if (shreg == BLOCK_CMD) begin
                  phase <= PH_ACK;
                  kind  <= BK_COUNT;
                end
              BK_COUNT: begin
                phase  <= PH_ACK;
                budget <= shreg;
                kind   <= BK_DATA;
                idx    <= '0;
              end
              BK_DATA:
                if (data_ok) begin
                  phase <= PH_ACK;
                  idx   <= idx + 8'd1;
                end
            endcase
          end
        end
        PH_ACK:
          if (scl_fall) begin
            bitcnt <= '0;
            if (rd_mode) begin
              phase <= PH_TX;
              txsh  <= rd_data;
            end else begin
              phase <= PH_RX;
            end
          end
        PH_TX:
          if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              phase <= PH_MACK;
            end else begin
              txsh   <= {txsh[6:0], 1'b1};
              bitcnt <= bitcnt + 3'd1;
            end
          end
        PH_MACK: begin
          if (scl_rise) begin
            host_ack <= !sda_s;
            if (!sda_s) idx <= idx + 8'd1;
          end
          if (scl_fall) begin
            bitcnt <= '0;
            if (host_ack) begin
              phase <= PH_TX;
              txsh  <= rd_data;
            end else begin
              phase <= PH_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/clkctl_i2c_slave.sv
module clkctl_i2c_slave #(
  parameter int         NUM_REGS     = 6,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [7:0] DEFAULT_FILL = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [8*NUM_REGS-1:0] ctrl_regs
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data;

  clkctl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  clkctl_i2c_fsm #(.NUM_REGS(NUM_REGS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx)
  );

  clkctl_regbank #(.NUM_REGS(NUM_REGS), .DEFAULT_FILL(DEFAULT_FILL)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .regs_flat(ctrl_regs)
  );
endmodule

// File: rtl/clkctl_i2c_chk.sv
module clkctl_i2c_chk #(
  parameter int NUM_REGS = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sda_oe,
  input logic [8*NUM_REGS-1:0] ctrl_regs,
  input logic                  scl_s,
  input logic                  scl_fall,
  input logic                  stop_det,
  input logic                  wr_en
);
  // R8
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R5
  write_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);

  // R3
  regs_change_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_regs) |-> $past(wr_en));

  // R2
  pull_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R7
  sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
endmodule

bind clkctl_i2c_slave clkctl_i2c_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .ctrl_regs(ctrl_regs),
  .scl_s(scl_s), .scl_fall(scl_fall), .stop_det(stop_det), .wr_en(wr_en)
);

// File: tb/tb_clkctl_i2c_slave.sv
module tb_clkctl_i2c_slave;
  localparam int NREG = 6;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [8*NREG-1:0] ctrl_regs;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [NREG];

  always #10 clk = ~clk;

  clkctl_i2c_slave #(.NUM_REGS(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .ctrl_regs(ctrl_regs)
  );

  // entry: {addr, cmd, count, bytes sent, seed}
  localparam logic [39:0] VEC [8] = '{
    {8'hD2, 8'h00, 8'd6, 8'd6, 8'h10},
    {8'hD2, 8'h00, 8'd2, 8'd6, 8'h40},
    {8'hD2, 8'h00, 8'd9, 8'd8, 8'h70},
    {8'hD4, 8'h00, 8'd6, 8'd6, 8'hA0},
    {8'hD2, 8'h05, 8'd6, 8'd6, 8'hB0},
    {8'hD2, 8'h00, 8'd0, 8'd2, 8'hC0},
    {8'hD2, 8'h00, 8'd3, 8'd3, 8'hE0},
    {8'hD2, 8'h00, 8'd6, 8'd4, 8'h01}
  };

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    scl = 1'b0; sda_m = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1'b1; tick(2*Q);
      scl = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    acked = (sda_bus == 1'b0);
    tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      d = {d[6:0], sda_bus};
      tick(Q);
      scl = 1'b0; tick(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic check_regs(string req);
    for (int i = 0; i < NREG; i++)
      chk(ctrl_regs[8*i +: 8] == model[i], req, ctrl_regs[8*i +: 8], model[i]);
  endtask

  task automatic read_back(string req);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD3, a);
    chk(a, "R7 read address ack", a, 1);
    for (int i = 0; i <= NREG; i++) begin
      read_byte(i < NREG, d);
      chk(d == ((i < NREG) ? model[i] : 8'hFF), req, d, (i < NREG) ? model[i] : 8'hFF);
    end
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    bit a;
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) model[i] = 8'hFF;
    tick(5);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 sda_oe at reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);
    check_regs("R1 reset defaults");

    foreach (VEC[v]) begin
      logic [7:0] ad, cm, cn, ns, sd;
      bit ok_a, ok_c;
      {ad, cm, cn, ns, sd} = VEC[v];
      ok_a = (ad == 8'hD2);
      ok_c = ok_a && (cm == 8'h00);
      bus_start();
      send_byte(ad, a);
      chk(a == ok_a, "R2/R3 address ack", a, ok_a);
      send_byte(cm, a);
      chk(a == ok_c, "R4 command ack", a, ok_c);
      send_byte(cn, a);
      chk(a == ok_c, "R5 count ack", a, ok_c);
      for (int k = 0; k < int'(ns); k++) begin
        logic [7:0] db;
        bit exp_w;
        db = sd + 8'(k * 8'h13);
        exp_w = ok_c && (k < int'(cn)) && (k < NREG);
        send_byte(db, a);
        chk(a == exp_w, "R5/R6 data ack", a, exp_w);
        if (exp_w) model[k] = db;
      end
      bus_stop();
      check_regs("R5/R6 register contents");
      read_back("R7 read data");
    end

    // R8 byte after stop and without start is ignored
    send_byte(8'hD2, a);
    chk(a == 1'b0, "R8 no ack after stop", a, 0);
    bus_stop();
    check_regs("R8 registers kept");

    // R9 repeated start during write
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'd6, a);
    send_byte(8'h5A, a);
    model[0] = 8'h5A;
    bus_start();
    send_byte(8'hD3, a);
    chk(a, "R9 address after repeated start", a, 1);
    read_byte(1'b0, d);
    chk(d == 8'h5A, "R9 register kept across restart", d, 8'h5A);
    // R7 after host nack the slave stays off the line
    read_byte(1'b0, d);
    chk(d == 8'hFF, "R7 silent after nack", d, 8'hFF);
    bus_stop();
    check_regs("R9 registers after restart");

    // R1 reset mid-run restores defaults
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    for (int i = 0; i < NREG; i++) model[i] = 8'hFF;
    check_regs("R1 defaults after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule